// File: doc/BRIEF.md
# Per-Bank Auto-Precharge Timing Tracker

This block follows a single DRAM bank from the controller's point of view. It watches the commands the controller issues to that bank: activate, read, write and an explicit precharge. Reads and writes carry the column address bit 10 flag, which asks for automatic precharge. The block works out the clock cycle in which the bank starts precharging. It reports whether the bank is idle, open or precharging, and it raises a permission flag in the cycles where a new activate would satisfy every row timing rule.

A read with bit 10 set schedules precharge after the posted additive latency plus the read-to-precharge time. That start is held back while the minimum active time since the activate has not yet run out. A write with bit 10 set waits for the end of its data burst and then for the write recovery time. After precharge begins, the bank is idle again once the precharge time has elapsed. A new activate is accepted only when the precharge time and the row cycle time since the previous activate are both met.

Commands that break the protocol are dropped and raise a one-cycle error flag. All timing values are parameters counted in clock cycles. T_RP must be at least 2, T_RAS at least 1, and T_RC at least T_RAS.

Top module: `bank_ap_tracker`

## Requirements
- R1: Reset state and encodings. While reset is asserted and after it is released, with no commands, `bank_state` reads 0 (idle), `act_ok` is 1, and `pre_start` and `proto_err` are 0. The `bank_state` encoding is 0 = idle, 1 = open, 2 = precharging.
- R2: An activate sampled while `act_ok` is high, with no other strobe, makes `bank_state` read 1 in the next cycle. It also restarts the row cycle count, so `act_ok` next rises T_RC edges after that activate at the earliest.
- R3: A read or write sampled while the bank is open and nothing is scheduled, with `a10` low, is accepted. The bank stays open and `pre_start` does not pulse for it.
- R4: A read accepted with `a10` high at edge n starts precharge at edge n+AL+T_RTP, provided at least T_RAS edges separate that edge from the activate.
- R5: When that read-scheduled edge comes fewer than T_RAS edges after the activate, precharge starts at the activate edge plus T_RAS instead.
- R6: A write accepted with `a10` high at edge n starts precharge at edge n+AL+CWL+BL/2+T_WR. This start is also never earlier than T_RAS edges after the activate.
- R7: A lone precharge command sampled while the bank is open with nothing scheduled starts precharge at that edge if at least T_RAS edges separate it from the activate. Otherwise it raises `proto_err` and the bank stays open.
- R8: Precharge starting at edge s makes the bank idle from edge s+T_RP-1 onwards. An activate is therefore accepted no earlier than edge s+T_RP, and only if that edge is also at least T_RC edges after the previous activate.
- R9: A read or write sampled while the bank is idle, precharging, or open with auto-precharge already scheduled raises `proto_err` and changes nothing.
- R10: An activate sampled while `act_ok` is low raises `proto_err` and changes nothing.
- R11: Two or more command strobes sampled in the same cycle raise `proto_err`, and all of them are ignored.
- R12: `pre_start` is high for exactly one cycle per precharge. That cycle is the first one in which `bank_state` reads 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all commands sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_act | input | 1 | Activate strobe |
| cmd_rd | input | 1 | Read strobe |
| cmd_wr | input | 1 | Write strobe |
| cmd_pre | input | 1 | Explicit precharge strobe |
| a10 | input | 1 | Auto-precharge request flag qualifying read and write |
| bank_state | output | 2 | 0 idle, 1 open, 2 precharging |
| pre_start | output | 1 | One-cycle pulse in the first precharging cycle |
| act_ok | output | 1 | An activate sampled at the next edge would be accepted |
| proto_err | output | 1 | One-cycle flag after a rejected command |

## Verification
A wrong internal count shows up at the ports within one cycle of the edge it affects. The count is wrong if the auto-precharge countdown, the active-time age or the precharge timer is off. The result is that `pre_start` and the change of `bank_state` to 2 come an edge early or late, or that `act_ok` rises too soon or too late. A wrong decision on a command shows up in the very next cycle as a missing or extra `proto_err`, or as a state that should not have moved. Every cycle is compared against a model built from edge numbers, so a one-edge slip in any timer is caught at the edge where it happens.

// File: rtl/bat_pkg.sv
package bat_pkg;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_PRE  = 2'd2
  } bk_state_e;

  // edges from an accepted read-with-auto-precharge to the precharge edge
  function automatic int rd_ap_delay(int al, int rtp);
    return al + rtp;
  endfunction

  // edges from an accepted write-with-auto-precharge to the precharge edge
  function automatic int wr_ap_delay(int al, int cwl, int bl, int wr);
    return al + cwl + (bl / 2) + wr;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bat_act_timer.sv
// Age since the last accepted activate, saturating at T_RC.
module bat_act_timer #(
  parameter int T_RAS = 15,
  parameter int T_RC  = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_take,
  output logic tras_met,
  output logic trc_met
);
  localparam int CW = $clog2(T_RC + 1);
  localparam logic [CW-1:0] AGE_SAT = CW'(T_RC);
  localparam logic [CW-1:0] RAS_M1  = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RC_M1   = CW'(T_RC - 1);

  logic [CW-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               age <= AGE_SAT;
    else if (act_take)        age <= '0;
    else if (age != AGE_SAT)  age <= age + 1'b1;
  end

  // "met" means: a command sampled at the coming edge is far enough away
  assign tras_met = (age >= RAS_M1);
  assign trc_met  = (age >= RC_M1);
endmodule

// File: rtl/bat_ap_sched.sv
// Countdown from an auto-precharge request to the edge it becomes due.
module bat_ap_sched #(
  parameter int RD_DLY = 4,
  parameter int WR_DLY = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic arm_wr,
  input  logic clr,
  output logic armed,
  output logic due
);
  import bat_pkg::*;
  localparam int DMAX = imax(imax(RD_DLY, WR_DLY), 1);
  localparam int AW   = $clog2(DMAX + 1);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] load_val;
  logic [AW-1:0] cnt;

  generate
    if (RD_DLY == WR_DLY) begin : g_same
      assign load_val = AW'(RD_DLY);
      logic unused_sel;
      assign unused_sel = arm_wr;
    end else begin : g_diff
      assign load_val = arm_wr ? AW'(WR_DLY) : AW'(RD_DLY);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= ONE;
      armed <= 1'b0;
    end else if (arm) begin
      cnt   <= load_val;
      armed <= 1'b1;
    end else if (clr) begin
      armed <= 1'b0;
    end else if (armed && cnt > ONE) begin
      cnt <= cnt - 1'b1;
    end
  end

  // holds at one once reached, so a late active-time release still fires
  assign due = armed && (cnt <= ONE);
endmodule

// File: rtl/bat_pre_timer.sv
// Counts precharging cycles; done marks the edge that returns the bank to idle.
module bat_pre_timer #(
  parameter int T_RP = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int PW = $clog2(T_RP + 1);
  localparam logic [PW-1:0] RP_M1 = PW'(T_RP - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (start)             cnt <= PW'(1);
    else if (run && cnt < RP_M1) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt >= RP_M1);
endmodule

// File: rtl/bank_ap_tracker.sv
module bank_ap_tracker #(
  parameter int AL    = 0,
  parameter int CWL   = 5,
  parameter int BL    = 8,
  parameter int T_RTP = 4,
  parameter int T_RAS = 15,
  parameter int T_RP  = 6,
  parameter int T_RC  = 21,
  parameter int T_WR  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_act,
  input  logic       cmd_rd,
  input  logic       cmd_wr,
  input  logic       cmd_pre,
  input  logic       a10,
  output logic [1:0] bank_state,
  output logic       pre_start,
  output logic       act_ok,
  output logic       proto_err
);
  import bat_pkg::*;

  localparam int RD_DLY = rd_ap_delay(AL, T_RTP);
  localparam int WR_DLY = wr_ap_delay(AL, CWL, BL, T_WR);

  bk_state_e st, st_nx;

  // named internal events, also used by the checker
  logic [2:0] n_cmd;
  logic       one_cmd, multi_cmd;
  logic       tras_ok, trc_ok;
  logic       ap_armed, ap_due;
  logic       pre_done;
  logic       act_take, rw_cmd, rw_take, ap_arm;
  logic       pre_take, ap_fire, pre_go;
  logic       err_nx;

  assign n_cmd     = {2'b0, cmd_act} + {2'b0, cmd_rd} + {2'b0, cmd_wr} + {2'b0, cmd_pre};
  assign one_cmd   = (n_cmd == 3'd1);
  assign multi_cmd = (n_cmd > 3'd1);

  assign act_ok   = (st == BK_IDLE) && trc_ok;
  assign act_take = one_cmd && cmd_act && act_ok;
  assign rw_cmd   = one_cmd && (cmd_rd || cmd_wr);
  assign rw_take  = rw_cmd && (st == BK_OPEN) && !ap_armed;
  assign ap_arm   = rw_take && a10;
  assign pre_take = one_cmd && cmd_pre && (st == BK_OPEN) && !ap_armed && tras_ok;
  assign ap_fire  = (st == BK_OPEN) && ap_due && tras_ok;
  assign pre_go   = pre_take || ap_fire;

  assign err_nx = multi_cmd
               || (one_cmd && cmd_act && !act_ok)
               || (rw_cmd && !rw_take)
               || (one_cmd && cmd_pre && !pre_take);

  bat_act_timer #(.T_RAS(T_RAS), .T_RC(T_RC)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_take (act_take),
    .tras_met (tras_ok),
    .trc_met  (trc_ok)
  );

  bat_ap_sched #(.RD_DLY(RD_DLY), .WR_DLY(WR_DLY)) u_ap (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (ap_arm),
    .arm_wr (cmd_wr),
    .clr    (ap_fire),
    .armed  (ap_armed),
    .due    (ap_due)
  );

  bat_pre_timer #(.T_RP(T_RP)) u_rp (
    .clk   (clk),
    .rst_n (rst_n),
    .start (pre_go),
    .run   (st == BK_PRE),
    .done  (pre_done)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      BK_IDLE: if (act_take) st_nx = BK_OPEN;
      BK_OPEN: if (pre_go)   st_nx = BK_PRE;
      BK_PRE:  if (pre_done) st_nx = BK_IDLE;
      default: st_nx = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= BK_IDLE;
      pre_start <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      st        <= st_nx;
      pre_start <= pre_go;
      proto_err <= err_nx;
    end
  end

  assign bank_state = st;
endmodule

// File: rtl/bat_checker.sv
module bat_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_act,
  input logic       cmd_rd,
  input logic       cmd_wr,
  input logic       cmd_pre,
  input logic [1:0] bank_state,
  input logic       pre_start,
  input logic       act_ok,
  input logic       proto_err,
  input logic       tras_ok,
  input logic       ap_armed
);
  logic lone_act, lone_rd, lone_pre, many;
  assign lone_act = cmd_act && !cmd_rd && !cmd_wr && !cmd_pre;
  assign lone_rd  = cmd_rd && !cmd_act && !cmd_wr && !cmd_pre;
  assign lone_pre = cmd_pre && !cmd_act && !cmd_rd && !cmd_wr;
  assign many     = $countones({cmd_act, cmd_rd, cmd_wr, cmd_pre}) > 1;

  a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bank_state != 2'd3);

  a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (lone_act && act_ok) |=> (bank_state == 2'd1));

  a_r3_no_spurious_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_state == 2'd1 && !ap_armed && !cmd_pre) |=> !pre_start);

  a_r5_pre_after_tras: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |-> $past(tras_ok));

  a_r7_early_pre_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_state == 2'd1 && lone_pre && !tras_ok) |=> (proto_err && bank_state == 2'd1));

  a_r8_open_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_state == 2'd1 && $past(bank_state) == 2'd0) |-> $past(act_ok));

  a_r9_rd_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (lone_rd && bank_state != 2'd1) |=> proto_err);

  a_r10_act_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (lone_act && !act_ok) |=> proto_err);

  a_r11_multi_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    many |=> proto_err);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |=> !pre_start);

  a_r12_pulse_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |-> (bank_state == 2'd2 && $past(bank_state) == 2'd1));
endmodule

bind bank_ap_tracker bat_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_act    (cmd_act),
  .cmd_rd     (cmd_rd),
  .cmd_wr     (cmd_wr),
  .cmd_pre    (cmd_pre),
  .bank_state (bank_state),
  .pre_start  (pre_start),
  .act_ok     (act_ok),
  .proto_err  (proto_err),
  .tras_ok    (tras_ok),
  .ap_armed   (ap_armed)
);

// File: tb/tb_bank_ap_tracker.sv
module tb_bank_ap_tracker;
  localparam int AL = 0, CWL = 5, BL = 8, T_RTP = 4;
  localparam int T_RAS = 15, T_RP = 6, T_RC = 21, T_WR = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_act = 0, cmd_rd = 0, cmd_wr = 0, cmd_pre = 0, a10 = 0;
  logic [1:0] bank_state;
  logic pre_start, act_ok, proto_err;

  always #4 clk = ~clk;

  bank_ap_tracker #(.AL(AL), .CWL(CWL), .BL(BL), .T_RTP(T_RTP), .T_RAS(T_RAS),
                    .T_RP(T_RP), .T_RC(T_RC), .T_WR(T_WR)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_pre(cmd_pre), .a10(a10), .bank_state(bank_state), .pre_start(pre_start),
    .act_ok(act_ok), .proto_err(proto_err));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model, in edge numbers
  int  n = 0;
  int  m_st = 0;
  bit  m_arm = 0, m_arm_wr = 0;
  int  m_ap_edge = 0, m_pre_edge = 0, m_act_edge = -1000;
  bit  exp_ps = 0, exp_err = 0, prev_ps = 0;
  string why = "R1";

  function automatic int rd_wait();
    return AL + T_RTP;
  endfunction
  function automatic int wr_wait();
    return AL + CWL + BL / 2 + T_WR;
  endfunction

  task automatic model(bit a, bit r, bit w, bit p, bit x);
    int  cnt;
    int  prev;
    bit  go;
    cnt = int'(a) + int'(r) + int'(w) + int'(p);
    prev = m_st;
    go = 0;
    exp_ps = 0;
    exp_err = 0;
    if (cnt > 1) begin
      exp_err = 1; why = "R11";
    end else if (a) begin
      if (prev == 0 && n - m_act_edge >= T_RC) begin
        m_st = 1; m_act_edge = n; why = "R2";
      end else begin
        exp_err = 1; why = "R10";
      end
    end else if (r || w) begin
      if (prev == 1 && !m_arm) begin
        if (x) begin
          m_arm = 1; m_arm_wr = w;
          m_ap_edge = n + (w ? wr_wait() : rd_wait());
          why = w ? "R6" : "R4";
        end else why = "R3";
      end else begin
        exp_err = 1; why = "R9";
      end
    end else if (p) begin
      why = "R7";
      if (prev == 1 && !m_arm && n - m_act_edge >= T_RAS) go = 1;
      else exp_err = 1;
    end
    if (!go && prev == 1 && m_arm && n >= m_ap_edge && n - m_act_edge >= T_RAS) begin
      go = 1;
      why = m_arm_wr ? "R6" : ((n > m_ap_edge) ? "R5" : "R4");
    end
    if (go) begin
      m_st = 2; m_pre_edge = n; m_arm = 0; exp_ps = 1;
    end else if (prev == 2 && n - m_pre_edge >= T_RP - 1) begin
      m_st = 0; why = "R8";
    end
    n++;
  endtask

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d (edge %0d)", why, tag, act, exp, n);
    end
  endtask

  task automatic compare_all();
    cmp("bank_state", int'(bank_state), m_st);
    cmp("pre_start", int'(pre_start), int'(exp_ps));
    cmp("act_ok", int'(act_ok), int'(m_st == 0 && n - m_act_edge >= T_RC));
    cmp("proto_err", int'(proto_err), int'(exp_err));
    if (prev_ps) begin
      checks++;
      if (pre_start) begin
        fails++;
        $display("FAIL R12: pre_start wider than one cycle actual=1 expected=0");
      end
    end
    prev_ps = pre_start;
  endtask

  // called at a falling edge: drive, take the rising edge, compare at next fall
  task automatic cyc(bit a, bit r, bit w, bit p, bit x);
    cmd_act = a; cmd_rd = r; cmd_wr = w; cmd_pre = p; a10 = x;
    @(posedge clk);
    model(a, r, w, p, x);
    @(negedge clk);
    cmd_act = 0; cmd_rd = 0; cmd_wr = 0; cmd_pre = 0; a10 = 0;
    compare_all();
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic wait_act_ok();
    for (int i = 0; i < 60 && !(m_st == 0 && n - m_act_edge >= T_RC); i++) idle(1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    why = "R1";
    compare_all();                 // R1 reset values
    rst_n = 1'b1;
    idle(2);                       // R1 after release

    // R2, R3: open, plain read and write, nothing scheduled
    cyc(1, 0, 0, 0, 0);
    idle(2);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    idle(25);
    // R7: explicit precharge, ok since tRAS long past
    cyc(0, 0, 0, 1, 0);
    // R10: activate while precharging
    cyc(1, 0, 0, 0, 0);
    // R9: read while precharging
    cyc(0, 1, 0, 0, 1);
    idle(T_RP);
    // R8: activate at first allowed edge
    wait_act_ok();
    cyc(1, 0, 0, 0, 0);
    // R7: early explicit precharge rejected
    cyc(0, 0, 0, 1, 0);
    // R5: read with auto-precharge right after activate, held by tRAS
    cyc(0, 1, 0, 0, 1);
    // R9: second read while scheduled
    cyc(0, 1, 0, 0, 1);
    idle(20);
    wait_act_ok();
    cyc(1, 0, 0, 0, 0);
    idle(T_RAS + 2);
    // R4: read with auto-precharge after tRAS already met
    cyc(0, 1, 0, 0, 1);
    idle(12);
    wait_act_ok();
    // R11: two strobes together
    cyc(1, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    // R6: write with auto-precharge
    cyc(0, 0, 1, 0, 1);
    idle(wr_wait() + T_RP + 2);
    // R9: write while idle
    cyc(0, 0, 1, 0, 1);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit x;
      r = $urandom_range(0, 99);
      x = 1'($urandom_range(0, 1));
      if (r < 2)       cyc(1, 0, 0, 1, x);
      else if (r < 14) cyc(1, 0, 0, 0, x);
      else if (r < 26) cyc(0, 1, 0, 0, x);
      else if (r < 36) cyc(0, 0, 1, 0, x);
      else if (r < 42) cyc(0, 0, 0, 1, x);
      else             cyc(0, 0, 0, 0, x);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule